// File: doc/BRIEF.md
# Battery Pack Protection and Feature Control Register

This block holds the host-visible protection byte and feature byte of a battery monitor. Comparator-style fault inputs for overvoltage, undervoltage, charge overcurrent and discharge overcurrent are captured as sticky flags. Each flag stays set until the host clears it with a write. Two host-written enable bits gate the charge and discharge paths. Any latched fault on a path also gates it, and so does the sleep state. Both enable bits are forced on when the monitor moves from sleep to active.

The feature byte covers two pins. The first is a power-switch pin. A low level on it requests wake-up while the monitor sleeps. While the monitor is active, a low level is captured into a bit that the host re-arms. The second is a general-purpose pin with a pull-low driver. Its latch is written by the host and read back as the pin level. The block releases that driver during sleep and when the serial bus data line has stayed low beyond a parameterised number of cycles. All pin inputs are assumed to be synchronous to `clk` already. Host writes and reads use a one-bit register select, and reads are combinational.

Top module: `batt_prot_ctrl`

## Requirements
- R1: After synchronous reset, all four fault flags are 0, both enable bits are 1, the power-switch bit is 1, the pin latch is 1 (driver released) and the bus-idle count is 0.
- R2: With rd_sel = 0 the read byte is, from bit 7 down: OV flag, UV flag, COC flag, DOC flag, charge mirror, discharge mirror, charge enable, discharge enable.
- R3: A fault input high at a clock edge sets its flag at that edge. The flag then stays set while the input is low, until a protection write carries 0 in that flag's bit. Writing 1 leaves the flag unchanged. A fault input high in the same cycle as the clearing write keeps the flag set.
- R4: Bits 3 and 2 of the protection byte show chg_on and dchg_on. Write data in those two bits has no effect.
- R5: chg_on is 1 only when awake is 1, charge enable is 1, and neither the OV flag nor the COC flag is set. dchg_on is 1 only when awake is 1, discharge enable is 1, and neither the UV flag nor the DOC flag is set.
- R6: A protection write loads wr_data bit 1 into charge enable and wr_data bit 0 into discharge enable.
- R7: At an edge where awake is 1 and was 0 at the previous edge, both enable bits become 1. This overrides a protection write in the same cycle.
- R8: wake_req is 1 exactly while awake is 0 and ps_pin_n is 0. While asleep, the power-switch bit does not change except through a host re-arm.
- R9: While awake, ps_pin_n low at an edge clears the power-switch bit. The bit stays 0 after the pin returns high, until a feature write with bit 1 = 1 sets it. Writing 0 to bit 1 has no effect. If the pin is low during the re-arm write, the bit stays 0.
- R10: With rd_sel = 1 the read byte carries the pio_pin level in bit 0, the power-switch bit in bit 1, and zeros in bits 7..2. A feature write loads bit 0 into the pin latch, and pio_drive_low is 1 when the latch is 0.
- R11: bus_dq low for IDLE_CYCLES consecutive edges times the bus out, and any high edge restarts the count. While timed out, or while awake is 0, pio_drive_low is 0 at once. The pin latch is then forced to 1 at the next edge, overriding feature writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_ov | input | 1 | Overvoltage condition present |
| fault_uv | input | 1 | Undervoltage condition present |
| fault_coc | input | 1 | Charge overcurrent condition present |
| fault_doc | input | 1 | Discharge overcurrent condition present |
| awake | input | 1 | 1 = active mode, 0 = sleep |
| ps_pin_n | input | 1 | Power-switch pin level, low = pressed |
| pio_pin | input | 1 | General-purpose pin level |
| bus_dq | input | 1 | Serial bus data line level |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 protection, 1 feature |
| wr_data | input | 8 | Host write data |
| rd_sel | input | 1 | Read source: 0 protection, 1 feature |
| rd_data | output | 8 | Selected register byte |
| chg_on | output | 1 | Charge path enabled |
| dchg_on | output | 1 | Discharge path enabled |
| pio_drive_low | output | 1 | Pull-low driver on for the general-purpose pin |
| wake_req | output | 1 | Request to leave sleep |

## Verification
The checker watches several rules on every cycle. It checks that a fault sets its flag, that set flags survive unless a write clears them, and that a fault cuts its path one cycle later. It also checks that a wake edge forces both enables, that a low power-switch pin while awake clears the bit, and that sleep forces the pin latch released. Some behaviour depends on ordering over several cycles, and only the bench scenarios show it. This covers event-versus-clear priority, re-arming with the pin still low, bus-idle restart after a short high pulse, and a write losing to the idle timeout. The bench also covers the exact byte layouts and the ignored mirror bits.

// File: rtl/batt_prot_pkg.sv
package batt_prot_pkg;

    typedef struct packed {
        logic ov;
        logic uv;
        logic coc;
        logic doc;
    } fault_t;

    typedef enum logic {
        SEL_PROT = 1'b0,
        SEL_FEAT = 1'b1
    } reg_sel_e;

    localparam int FEAT_PIO_BIT = 0;
    localparam int FEAT_PS_BIT  = 1;
    localparam int PROT_CE_BIT  = 1;
    localparam int PROT_DE_BIT  = 0;

    // flag bits occupy the upper nibble of the protection byte
    function automatic fault_t fault_field(input logic [7:0] b);
        return fault_t'(b[7:4]);
    endfunction

    function automatic logic [7:0] pack_prot(input fault_t f, input logic cc,
                                             input logic dc, input logic ce,
                                             input logic de);
        return {f, cc, dc, ce, de};
    endfunction

    function automatic logic [7:0] pack_feat(input logic pio_lvl, input logic ps);
        return {6'b0, ps, pio_lvl};
    endfunction

endpackage

// File: rtl/bp_fault_flags.sv
module bp_fault_flags
    import batt_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_t     evt,
    input  logic       clr_we,
    input  logic [7:0] wdata,
    output fault_t     flags_q
);
    logic [3:0] keep_mask;

    // a 0 in a written flag bit clears it; a 1 keeps it
    always_comb begin
        keep_mask = clr_we ? 4'(fault_field(wdata)) : 4'hF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= fault_t'((4'(flags_q) & keep_mask) | 4'(evt));
        end
    end
endmodule

// File: rtl/bp_path_enable.sv
module bp_path_enable
    import batt_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       awake,
    input  logic       prot_we,
    input  logic [7:0] wdata,
    input  fault_t     flags,
    output logic       ce_q,
    output logic       de_q,
    output logic       chg_on,
    output logic       dchg_on
);
    logic awake_q;
    logic wake_edge;

    assign wake_edge = awake & ~awake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            awake_q <= 1'b0;
            ce_q    <= 1'b1;
            de_q    <= 1'b1;
        end else begin
            awake_q <= awake;
            if (wake_edge) begin
                ce_q <= 1'b1;
                de_q <= 1'b1;
            end else if (prot_we) begin
                ce_q <= wdata[PROT_CE_BIT];
                de_q <= wdata[PROT_DE_BIT];
            end
        end
    end

    always_comb begin
        chg_on  = awake & ce_q & ~flags.ov & ~flags.coc;
        dchg_on = awake & de_q & ~flags.uv & ~flags.doc;
    end
endmodule

// File: rtl/bp_pin_ctrl.sv
module bp_pin_ctrl
    import batt_prot_pkg::*;
#(
    parameter int IDLE_CYCLES = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       awake,
    input  logic       ps_pin_n,
    input  logic       bus_dq,
    input  logic       feat_we,
    input  logic [7:0] wdata,
    output logic       ps_q,
    output logic       pio_q,
    output logic       pio_drive_low,
    output logic       wake_req,
    output logic       idle_to
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] idle_cnt;

    assign idle_to = (idle_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (bus_dq) begin
            idle_cnt <= '0;
        end else if (!idle_to) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // power-switch capture: pin low while active wins over re-arm
    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= 1'b1;
        end else if (awake && !ps_pin_n) begin
            ps_q <= 1'b0;
        end else if (feat_we && wdata[FEAT_PS_BIT]) begin
            ps_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pio_q <= 1'b1;
        end else if (!awake || idle_to) begin
            pio_q <= 1'b1;
        end else if (feat_we) begin
            pio_q <= wdata[FEAT_PIO_BIT];
        end
    end

    always_comb begin
        pio_drive_low = ~pio_q & awake & ~idle_to;
        wake_req      = ~awake & ~ps_pin_n;
    end
endmodule

// File: rtl/batt_prot_ctrl.sv
module batt_prot_ctrl
    import batt_prot_pkg::*;
#(
    parameter int IDLE_CYCLES = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fault_ov,
    input  logic       fault_uv,
    input  logic       fault_coc,
    input  logic       fault_doc,
    input  logic       awake,
    input  logic       ps_pin_n,
    input  logic       pio_pin,
    input  logic       bus_dq,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       chg_on,
    output logic       dchg_on,
    output logic       pio_drive_low,
    output logic       wake_req
);
    fault_t evt;
    fault_t flags_q;
    logic   prot_we;
    logic   feat_we;
    logic   ce_q;
    logic   de_q;
    logic   ps_q;
    logic   pio_q;
    logic   idle_to;

    assign evt     = '{ov: fault_ov, uv: fault_uv, coc: fault_coc, doc: fault_doc};
    assign prot_we = wr_en && (reg_sel_e'(wr_sel) == SEL_PROT);
    assign feat_we = wr_en && (reg_sel_e'(wr_sel) == SEL_FEAT);

    bp_fault_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr_we  (prot_we),
        .wdata   (wr_data),
        .flags_q (flags_q)
    );

    bp_path_enable u_path (
        .clk     (clk),
        .rst     (rst),
        .awake   (awake),
        .prot_we (prot_we),
        .wdata   (wr_data),
        .flags   (flags_q),
        .ce_q    (ce_q),
        .de_q    (de_q),
        .chg_on  (chg_on),
        .dchg_on (dchg_on)
    );

    bp_pin_ctrl #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_pins (
        .clk           (clk),
        .rst           (rst),
        .awake         (awake),
        .ps_pin_n      (ps_pin_n),
        .bus_dq        (bus_dq),
        .feat_we       (feat_we),
        .wdata         (wr_data),
        .ps_q          (ps_q),
        .pio_q         (pio_q),
        .pio_drive_low (pio_drive_low),
        .wake_req      (wake_req),
        .idle_to       (idle_to)
    );

    always_comb begin
        if (reg_sel_e'(rd_sel) == SEL_FEAT) begin
            rd_data = pack_feat(pio_pin, ps_q);
        end else begin
            rd_data = pack_prot(flags_q, chg_on, dchg_on, ce_q, de_q);
        end
    end
endmodule

// File: rtl/batt_prot_chk.sv
module batt_prot_chk
    import batt_prot_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input fault_t     evt,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       awake,
    input logic       ps_pin_n,
    input fault_t     flags_q,
    input logic       ce_q,
    input logic       de_q,
    input logic       ps_q,
    input logic       pio_q,
    input logic       chg_on,
    input logic       dchg_on
);
    logic [3:0] keep_now;
    assign keep_now = (wr_en && !wr_sel) ? wr_data[7:4] : 4'hF;

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
        (4'(evt) != 4'b0) |=> ((4'(flags_q) & $past(4'(evt))) == $past(4'(evt))));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ((4'(flags_q) & keep_now) != 4'b0)
        |=> ((4'(flags_q) & $past(4'(flags_q) & keep_now)) == $past(4'(flags_q) & keep_now)));

    assert_chg_cut_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.ov || evt.coc) |=> !chg_on);

    assert_dchg_cut_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.uv || evt.doc) |=> !dchg_on);

    assert_wake_force_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(awake) |=> (ce_q && de_q));

    assert_ps_asleep_R8: assert property (@(posedge clk) disable iff (rst)
        (!awake && !(wr_en && wr_sel && wr_data[1])) |=> $stable(ps_q));

    assert_ps_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (awake && !ps_pin_n) |=> !ps_q);

    assert_sleep_release_R11: assert property (@(posedge clk) disable iff (rst)
        !awake |=> pio_q);
endmodule

bind batt_prot_ctrl batt_prot_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .awake    (awake),
    .ps_pin_n (ps_pin_n),
    .flags_q  (flags_q),
    .ce_q     (ce_q),
    .de_q     (de_q),
    .ps_q     (ps_q),
    .pio_q    (pio_q),
    .chg_on   (chg_on),
    .dchg_on  (dchg_on)
);

// File: tb/batt_prot_ctrl_tb.sv
module batt_prot_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 8;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [3:0] ev;
        logic       we;
        logic [7:0] wd;
        logic [7:0] exp_prot;
    } vec_t;

    // protection-register vectors, applied with awake = 1
    localparam vec_t VECS [NVEC] = '{
        '{4'b1000, 1'b0, 8'h00, 8'h87},  // R3 OV set, R5 charge cut
        '{4'b0000, 1'b0, 8'h00, 8'h87},  // R3 sticky with input low
        '{4'b0000, 1'b1, 8'hFF, 8'h87},  // R3 writing 1 keeps flag
        '{4'b0000, 1'b1, 8'h7F, 8'h0F},  // R3 clear OV
        '{4'b0100, 1'b0, 8'h00, 8'h4B},  // R5 UV cuts discharge
        '{4'b0010, 1'b0, 8'h00, 8'h63},  // R5 COC cuts charge
        '{4'b0001, 1'b1, 8'h9F, 8'h1B},  // R3 clear UV/COC while DOC sets
        '{4'b0001, 1'b1, 8'hEF, 8'h1B},  // R3 event beats clear
        '{4'b0000, 1'b1, 8'hEF, 8'h0F},  // R3 clear DOC
        '{4'b0000, 1'b1, 8'h0D, 8'h05},  // R4 mirror bits ignored, R6 CE=0
        '{4'b0000, 1'b1, 8'h02, 8'h0A},  // R6 CE=1 DE=0
        '{4'b0000, 1'b1, 8'h00, 8'h00},  // R6 both off
        '{4'b1111, 1'b0, 8'h00, 8'hF0},  // R2 all flags
        '{4'b0000, 1'b1, 8'h03, 8'h0F}   // R2 clear all, enables on
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       fault_ov, fault_uv, fault_coc, fault_doc;
    logic       awake, ps_pin_n, pio_pin, bus_dq;
    logic       wr_en, wr_sel;
    logic [7:0] wr_data;
    logic       rd_sel;
    logic [7:0] rd_data;
    logic       chg_on, dchg_on, pio_drive_low, wake_req;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_prot_ctrl #(.IDLE_CYCLES(IDLE)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .fault_ov      (fault_ov),
        .fault_uv      (fault_uv),
        .fault_coc     (fault_coc),
        .fault_doc     (fault_doc),
        .awake         (awake),
        .ps_pin_n      (ps_pin_n),
        .pio_pin       (pio_pin),
        .bus_dq        (bus_dq),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .chg_on        (chg_on),
        .dchg_on       (dchg_on),
        .pio_drive_low (pio_drive_low),
        .wake_req      (wake_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = 8'h00;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1;
        {fault_ov, fault_uv, fault_coc, fault_doc} = 4'b0;
        awake = 1'b1; ps_pin_n = 1'b1; pio_pin = 1'b1; bus_dq = 1'b1;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; rd_sel = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        #1;

        // R1 reset state
        rd(1'b0, v); check("R1 protection byte", v, 8'h0F);
        rd(1'b1, v); check("R1 feature byte", v, 8'h03);
        check("R1 driver released", {7'b0, pio_drive_low}, 8'h00);
        check("R1 no wake request", {7'b0, wake_req}, 8'h00);

        // R2 R3 R4 R5 R6 vector table
        rd_sel = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            {fault_ov, fault_uv, fault_coc, fault_doc} = VECS[i].ev;
            wr_en = VECS[i].we; wr_sel = 1'b0; wr_data = VECS[i].wd;
            tick();
            {fault_ov, fault_uv, fault_coc, fault_doc} = 4'b0;
            wr_en = 1'b0;
            rd(1'b0, v);
            check($sformatf("R2/R3 vector %0d byte", i), v, VECS[i].exp_prot);
            check($sformatf("R5 vector %0d paths", i), {6'b0, chg_on, dchg_on},
                  {6'b0, VECS[i].exp_prot[3], VECS[i].exp_prot[2]});
        end

        // R5 sleep gates both paths
        awake = 1'b0;
        #1;
        check("R5 asleep paths off", {6'b0, chg_on, dchg_on}, 8'h00);
        tick();
        write(1'b0, 8'h00);
        rd(1'b0, v); check("R6 write while asleep", v, 8'h00);
        // R7 wake edge overrides same-cycle write
        awake = 1'b1;
        write(1'b0, 8'h00);
        rd(1'b0, v); check("R7 wake forces enables", v, 8'h0F);

        // R8 power switch while asleep
        awake = 1'b0; ps_pin_n = 1'b0;
        #1;
        check("R8 wake request", {7'b0, wake_req}, 8'h01);
        tick();
        rd(1'b1, v); check("R8 PS unchanged asleep", v, 8'h03);
        awake = 1'b1;
        #1;
        check("R8 no request when awake", {7'b0, wake_req}, 8'h00);
        tick();
        rd(1'b1, v); check("R9 PS captured", v, 8'h01);
        ps_pin_n = 1'b1;
        tick();
        rd(1'b1, v); check("R9 PS held after release", v, 8'h01);
        write(1'b1, 8'h01);
        rd(1'b1, v); check("R9 writing 0 ignored", v, 8'h01);
        write(1'b1, 8'h03);
        rd(1'b1, v); check("R9 re-arm", v, 8'h03);
        ps_pin_n = 1'b0;
        write(1'b1, 8'h03);
        rd(1'b1, v); check("R9 pin low beats re-arm", v, 8'h01);
        ps_pin_n = 1'b1;
        write(1'b1, 8'h03);
        rd(1'b1, v); check("R9 re-arm after release", v, 8'h03);

        // R10 pin latch and readback
        write(1'b1, 8'h02);
        check("R10 driver on", {7'b0, pio_drive_low}, 8'h01);
        pio_pin = 1'b0;
        rd(1'b1, v); check("R10 pin level read", v, 8'h02);

        // R11 bus idle timeout with restart
        bus_dq = 1'b0;
        repeat (IDLE - 1) tick();
        check("R11 before timeout", {7'b0, pio_drive_low}, 8'h01);
        bus_dq = 1'b1;
        tick();
        bus_dq = 1'b0;
        repeat (IDLE - 1) tick();
        check("R11 count restarted", {7'b0, pio_drive_low}, 8'h01);
        tick();
        check("R11 timeout releases", {7'b0, pio_drive_low}, 8'h00);
        write(1'b1, 8'h02);
        bus_dq = 1'b1;
        tick();
        pio_pin = 1'b1;
        check("R11 write during timeout lost", {7'b0, pio_drive_low}, 8'h00);
        write(1'b1, 8'h02);
        check("R10 driver on again", {7'b0, pio_drive_low}, 8'h01);
        awake = 1'b0;
        #1;
        check("R11 sleep releases at once", {7'b0, pio_drive_low}, 8'h00);
        tick();
        awake = 1'b1;
        tick();
        check("R11 latch forced by sleep", {7'b0, pio_drive_low}, 8'h00);

        finish_run();
    end
endmodule